// File: doc/BRIEF.md
# Fractional PLL Output Rate Calculator

This block works out the output frequency that a fractional-N PLL would produce for a given reference frequency and set of divider fields. On a start strobe it captures the reference frequency, the integer multiplier, the fractional numerator and denominator, the reference-divider code, the output-divider code and a mode bit. It builds a wide numerator and denominator from these fields, then divides them with a shift-subtract divider that retires one quotient bit per cycle.

A small built-in table of known exact settings takes precedence: when the captured fields match an entry, that entry's rate is returned at once and no division runs. The block also reports whether the implied VCO frequency lies outside its allowed window, and it rejects a zero fractional denominator with a flag instead of dividing by zero. Results appear together with a one-cycle done pulse and are held until the next result.

The control flow is a five-state machine. IDLE waits for start and captures the operands (IDLE→CALC). CALC forms the operands and picks a route: a zero denominator or a table hit goes straight to DONE (CALC→DONE), anything else loads the divider (CALC→DIVIDE). DIVIDE runs one step per cycle and leaves for LATCH after the last step (DIVIDE→LATCH). LATCH stores the quotient (LATCH→DONE), and DONE returns to IDLE after one cycle (DONE→IDLE).

Top module: `pll_rate_calc`

## Requirements
- R1: While reset is asserted and after its release, rate_o, done_o, range_err_o and div_zero_o are all 0 until the first result.
- R2: With frac_mode_i=1, rate_o = floor(Fref × (MFI × MFD + MFN) / (MFD × Rdiv × Odiv)), where Rdiv and Odiv are the decoded divider values.
- R3: With frac_mode_i=0, rate_o = floor(Fref × MFI / (Rdiv × Odiv)) and the values on mfn_i and mfd_i have no effect on any output.
- R4: An rdiv_i code of 0 divides by 1, and any other code divides by its own value; an odiv_i code of 0 divides by 2, a code of 1 divides by 3, and any other code divides by its own value.
- R5: If the captured fields match a table entry, rate_o is the table rate instead of the computed value. Fractional entries match on all five fields (one is MFI=162, MFN=50, MFD=100, rdiv code 0, odiv code 6, giving 650000000). Integer entries apply only with frac_mode_i=0 and match on MFI and the two codes only (one is MFI=141, rdiv code 1, odiv code 2, giving 1700000000).
- R6: range_err_o is 1 when the VCO frequency Fref × (MFI + MFN/MFD) / Rdiv is below 2.5 GHz or above 5 GHz. In integer mode the fraction term is dropped. Both bounds count as inside the window, and the flag is evaluated even when a table entry supplies the rate.
- R7: With frac_mode_i=1 and mfd_i=0, rate_o is 0, div_zero_o is 1 and range_err_o is 0; div_zero_o is 0 for every other result.
- R8: Counting the rising edge that samples start_i as edge 1, done_o is first high after edge 2 for a table hit or a zero denominator, and after edge 67 for a divided result.
- R9: done_o is high for exactly one cycle per result. rate_o, range_err_o and div_zero_o change only in the cycle that done_o is high, and they hold their values until the next result.
- R10: A start_i pulse that arrives while a calculation is in progress is ignored: the running result and its latency are unaffected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start strobe, sampled only in IDLE |
| frac_mode_i | input | 1 | 1 = fractional mode, 0 = integer mode |
| ref_freq_i | input | 32 | Reference frequency in Hz |
| mfi_i | input | 9 | Integer multiplier |
| mfn_i | input | 30 | Fractional numerator |
| mfd_i | input | 30 | Fractional denominator |
| rdiv_i | input | 3 | Reference divider code |
| odiv_i | input | 8 | Output divider code |
| rate_o | output | 64 | Computed or table output frequency in Hz |
| done_o | output | 1 | One-cycle result strobe |
| range_err_o | output | 1 | VCO frequency outside the allowed window |
| div_zero_o | output | 1 | Zero fractional denominator was rejected |

## Verification
A table override and a range error can be reported in the same done cycle. This is provoked by feeding the 650 MHz table fields with a 10 MHz reference, which puts the VCO at 1.625 GHz. The bench then expects rate_o to carry the table value while range_err_o is 1, both with the short table latency. The inclusive window edges are tested at exactly 2.5 GHz and exactly 5 GHz.

// File: rtl/pll_rate_pkg.sv
package pll_rate_pkg;

    localparam int REF_W  = 32;
    localparam int MFI_W  = 9;
    localparam int MFN_W  = 30;
    localparam int MFD_W  = 30;
    localparam int RDIV_W = 3;
    localparam int ODIV_W = 8;
    localparam int TAB_N  = 12;

    typedef enum logic [2:0] {
        S_IDLE,
        S_CALC,
        S_DIVIDE,
        S_LATCH,
        S_DONE
    } calc_state_e;

    typedef struct packed {
        logic              int_only;
        logic [MFI_W-1:0]  mfi;
        logic [MFN_W-1:0]  mfn;
        logic [MFD_W-1:0]  mfd;
        logic [RDIV_W-1:0] rdiv;
        logic [ODIV_W-1:0] odiv;
        logic [31:0]       rate;
    } known_setting_t;

    localparam known_setting_t KNOWN_TAB [TAB_N] = '{
        '{1'b0, 9'd162, 30'd50, 30'd100, 3'd0, 8'd6,  32'd650000000},
        '{1'b0, 9'd198, 30'd0,  30'd1,   3'd0, 8'd8,  32'd594000000},
        '{1'b0, 9'd140, 30'd0,  30'd1,   3'd0, 8'd6,  32'd560000000},
        '{1'b0, 9'd166, 30'd0,  30'd1,   3'd0, 8'd8,  32'd498000000},
        '{1'b0, 9'd121, 30'd0,  30'd1,   3'd0, 8'd6,  32'd484000000},
        '{1'b0, 9'd167, 30'd0,  30'd1,   3'd0, 8'd9,  32'd445333333},
        '{1'b0, 9'd200, 30'd0,  30'd1,   3'd0, 8'd12, 32'd400000000},
        '{1'b0, 9'd163, 30'd84, 30'd100, 3'd0, 8'd10, 32'd393216000},
        '{1'b0, 9'd150, 30'd0,  30'd1,   3'd0, 8'd12, 32'd300000000},
        '{1'b1, 9'd141, 30'd0,  30'd0,   3'd1, 8'd2,  32'd1700000000},
        '{1'b1, 9'd175, 30'd0,  30'd0,   3'd1, 8'd3,  32'd1400000000},
        '{1'b1, 9'd150, 30'd0,  30'd0,   3'd1, 8'd4,  32'd900000000}
    };

endpackage

// File: rtl/rate_operand_prep.sv
// Forms dividend, divisor and the VCO window check from captured fields.
module rate_operand_prep
    import pll_rate_pkg::*;
#(
    parameter int          DIV_W   = 64,
    parameter logic [63:0] VCO_MIN = 64'd2500000000,
    parameter logic [63:0] VCO_MAX = 64'd5000000000
) (
    input  logic              frac_i,
    input  logic [REF_W-1:0]  ref_i,
    input  logic [MFI_W-1:0]  mfi_i,
    input  logic [MFN_W-1:0]  mfn_i,
    input  logic [MFD_W-1:0]  mfd_i,
    input  logic [RDIV_W-1:0] rdiv_i,
    input  logic [ODIV_W-1:0] odiv_i,
    output logic [DIV_W-1:0]  num_o,
    output logic [DIV_W-1:0]  den_o,
    output logic              den_zero_o,
    output logic              vco_err_o
);
    localparam int WIDE_W = 2 * DIV_W;

    logic [WIDE_W-1:0] rdiv_eff, odiv_eff, mfd_eff, mfn_eff;
    logic [WIDE_W-1:0] mult_sum, num_full, vco_den, den_full;
    logic [WIDE_W-1:0] lo_bound, hi_bound;

    always_comb begin
        rdiv_eff = (rdiv_i == '0) ? WIDE_W'(1) : WIDE_W'(rdiv_i);
        unique case (odiv_i)
            8'd0:    odiv_eff = WIDE_W'(2);
            8'd1:    odiv_eff = WIDE_W'(3);
            default: odiv_eff = WIDE_W'(odiv_i);
        endcase
        mfd_eff  = frac_i ? WIDE_W'(mfd_i) : WIDE_W'(1);
        mfn_eff  = frac_i ? WIDE_W'(mfn_i) : '0;
        mult_sum = WIDE_W'(mfi_i) * mfd_eff + mfn_eff;
        num_full = WIDE_W'(ref_i) * mult_sum;
        vco_den  = mfd_eff * rdiv_eff;
        den_full = vco_den * odiv_eff;
        lo_bound = WIDE_W'(VCO_MIN) * vco_den;
        hi_bound = WIDE_W'(VCO_MAX) * vco_den;
    end

    assign num_o      = num_full[DIV_W-1:0];
    assign den_o      = den_full[DIV_W-1:0];
    assign den_zero_o = (den_full == '0);
    assign vco_err_o  = !den_zero_o && ((num_full < lo_bound) || (num_full > hi_bound));

endmodule

// File: rtl/rate_table_match.sv
// Compares captured fields with every stored setting; first hit wins.
module rate_table_match
    import pll_rate_pkg::*;
#(
    parameter int DIV_W = 64
) (
    input  logic              frac_i,
    input  logic [MFI_W-1:0]  mfi_i,
    input  logic [MFN_W-1:0]  mfn_i,
    input  logic [MFD_W-1:0]  mfd_i,
    input  logic [RDIV_W-1:0] rdiv_i,
    input  logic [ODIV_W-1:0] odiv_i,
    output logic              hit_o,
    output logic [DIV_W-1:0]  rate_o
);
    logic [TAB_N-1:0] match;

    for (genvar g = 0; g < TAB_N; g++) begin : g_entry
        assign match[g] = (KNOWN_TAB[g].int_only == !frac_i)
                       && (KNOWN_TAB[g].mfi  == mfi_i)
                       && (KNOWN_TAB[g].rdiv == rdiv_i)
                       && (KNOWN_TAB[g].odiv == odiv_i)
                       && (KNOWN_TAB[g].int_only
                           || ((KNOWN_TAB[g].mfn == mfn_i) && (KNOWN_TAB[g].mfd == mfd_i)));
    end

    always_comb begin
        hit_o  = 1'b0;
        rate_o = '0;
        for (int i = TAB_N - 1; i >= 0; i--) begin
            if (match[i]) begin
                hit_o  = 1'b1;
                rate_o = DIV_W'(KNOWN_TAB[i].rate);
            end
        end
    end

endmodule

// File: rtl/rate_divider.sv
// Restoring divider: one quotient bit per step, MSB first.
module rate_divider #(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic         step_i,
    input  logic [W-1:0] num_i,
    input  logic [W-1:0] den_i,
    output logic [W-1:0] quot_o
);
    logic [W-1:0] rem_q, quot_q, den_q;
    logic [W:0]   shifted, trial;

    always_comb begin
        shifted = {rem_q, quot_q[W-1]};
        trial   = shifted - {1'b0, den_q};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q  <= '0;
            quot_q <= '0;
            den_q  <= '0;
        end else if (load_i) begin
            rem_q  <= '0;
            quot_q <= num_i;
            den_q  <= den_i;
        end else if (step_i) begin
            if (!trial[W]) begin
                rem_q  <= trial[W-1:0];
                quot_q <= {quot_q[W-2:0], 1'b1};
            end else begin
                rem_q  <= shifted[W-1:0];
                quot_q <= {quot_q[W-2:0], 1'b0};
            end
        end
    end

    assign quot_o = quot_q;

endmodule

// File: rtl/pll_rate_calc.sv
module pll_rate_calc
    import pll_rate_pkg::*;
#(
    parameter int          DIV_W   = 64,
    parameter logic [63:0] VCO_MIN = 64'd2500000000,
    parameter logic [63:0] VCO_MAX = 64'd5000000000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              frac_mode_i,
    input  logic [REF_W-1:0]  ref_freq_i,
    input  logic [MFI_W-1:0]  mfi_i,
    input  logic [MFN_W-1:0]  mfn_i,
    input  logic [MFD_W-1:0]  mfd_i,
    input  logic [RDIV_W-1:0] rdiv_i,
    input  logic [ODIV_W-1:0] odiv_i,
    output logic [DIV_W-1:0]  rate_o,
    output logic              done_o,
    output logic              range_err_o,
    output logic              div_zero_o
);
    localparam int CNT_W = $clog2(DIV_W);

    calc_state_e state_q, state_d;

    logic              op_frac;
    logic [REF_W-1:0]  op_ref;
    logic [MFI_W-1:0]  op_mfi;
    logic [MFN_W-1:0]  op_mfn;
    logic [MFD_W-1:0]  op_mfd;
    logic [RDIV_W-1:0] op_rdiv;
    logic [ODIV_W-1:0] op_odiv;
    logic [CNT_W-1:0]  step_cnt;
    logic              pend_range;

    logic [DIV_W-1:0]  num_c, den_c, hit_rate_c, quot_c;
    logic              den_zero_c, vco_err_c, hit_c, shortcut_c;

    rate_operand_prep #(.DIV_W(DIV_W), .VCO_MIN(VCO_MIN), .VCO_MAX(VCO_MAX)) u_prep (
        .frac_i(op_frac), .ref_i(op_ref), .mfi_i(op_mfi), .mfn_i(op_mfn),
        .mfd_i(op_mfd), .rdiv_i(op_rdiv), .odiv_i(op_odiv),
        .num_o(num_c), .den_o(den_c), .den_zero_o(den_zero_c), .vco_err_o(vco_err_c)
    );

    rate_table_match #(.DIV_W(DIV_W)) u_table (
        .frac_i(op_frac), .mfi_i(op_mfi), .mfn_i(op_mfn), .mfd_i(op_mfd),
        .rdiv_i(op_rdiv), .odiv_i(op_odiv), .hit_o(hit_c), .rate_o(hit_rate_c)
    );

    rate_divider #(.W(DIV_W)) u_div (
        .clk(clk), .rst_n(rst_n),
        .load_i(state_q == S_CALC && !shortcut_c),
        .step_i(state_q == S_DIVIDE),
        .num_i(num_c), .den_i(den_c), .quot_o(quot_c)
    );

    assign shortcut_c = den_zero_c || hit_c;

    // Next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:   if (start_i) state_d = S_CALC;
            S_CALC:   state_d = shortcut_c ? S_DONE : S_DIVIDE;
            S_DIVIDE: if (step_cnt == CNT_W'(DIV_W - 1)) state_d = S_LATCH;
            S_LATCH:  state_d = S_DONE;
            S_DONE:   state_d = S_IDLE;
            default:  state_d = S_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Operand capture, step counter and pending range flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_frac    <= 1'b0;
            op_ref     <= '0;
            op_mfi     <= '0;
            op_mfn     <= '0;
            op_mfd     <= '0;
            op_rdiv    <= '0;
            op_odiv    <= '0;
            step_cnt   <= '0;
            pend_range <= 1'b0;
        end else begin
            if (state_q == S_IDLE && start_i) begin
                op_frac <= frac_mode_i;
                op_ref  <= ref_freq_i;
                op_mfi  <= mfi_i;
                op_mfn  <= mfn_i;
                op_mfd  <= mfd_i;
                op_rdiv <= rdiv_i;
                op_odiv <= odiv_i;
            end
            if (state_q == S_CALC) begin
                step_cnt   <= '0;
                pend_range <= vco_err_c;
            end else if (state_q == S_DIVIDE) begin
                step_cnt <= step_cnt + 1'b1;
            end
        end
    end

    // Outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rate_o      <= '0;
            done_o      <= 1'b0;
            range_err_o <= 1'b0;
            div_zero_o  <= 1'b0;
        end else begin
            done_o <= (state_d == S_DONE);
            if (state_q == S_CALC && shortcut_c) begin
                rate_o      <= den_zero_c ? '0 : hit_rate_c;
                range_err_o <= vco_err_c;
                div_zero_o  <= den_zero_c;
            end else if (state_q == S_LATCH) begin
                rate_o      <= quot_c;
                range_err_o <= pend_range;
                div_zero_o  <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/pll_rate_calc_chk.sv
module pll_rate_calc_chk #(
    parameter int DIV_W = 64
) (
    input logic             clk,
    input logic             rst_n,
    input logic [DIV_W-1:0] rate_o,
    input logic             done_o,
    input logic             range_err_o,
    input logic             div_zero_o
);
    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R9
    rate_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable(rate_o));

    // R9
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable({range_err_o, div_zero_o}));

    // R7
    zero_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        div_zero_o |-> (rate_o == '0 && !range_err_o));

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (!done_o && rate_o == '0));

endmodule

bind pll_rate_calc pll_rate_calc_chk #(.DIV_W(DIV_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .rate_o(rate_o), .done_o(done_o),
    .range_err_o(range_err_o), .div_zero_o(div_zero_o)
);

// File: tb/pll_rate_calc_bench.sv
module pll_rate_calc_bench;

    typedef struct packed {
        logic        frac;
        logic [31:0] fref;
        logic [8:0]  mfi;
        logic [29:0] mfn;
        logic [29:0] mfd;
        logic [2:0]  rdiv;
        logic [7:0]  odiv;
        logic [63:0] rate;
        logic        rng;
        logic        zro;
        logic [7:0]  lat;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 32'd24000000, 9'd100, 30'd1,  30'd3,   3'd0, 8'd4,  64'd602000000,  1'b1, 1'b0, 8'd67}, // R2 R6 low VCO
        '{1'b1, 32'd24000000, 9'd125, 30'd1,  30'd4,   3'd1, 8'd0,  64'd1503000000, 1'b0, 1'b0, 8'd67}, // R2 R4 odiv 0
        '{1'b0, 32'd24000000, 9'd150, 30'd7,  30'd0,   3'd0, 8'd1,  64'd1200000000, 1'b0, 1'b0, 8'd67}, // R3 R4
        '{1'b0, 32'd24000000, 9'd141, 30'd5,  30'd9,   3'd1, 8'd2,  64'd1700000000, 1'b0, 1'b0, 8'd2},  // R5 integer entry
        '{1'b1, 32'd24000000, 9'd162, 30'd50, 30'd100, 3'd0, 8'd6,  64'd650000000,  1'b0, 1'b0, 8'd2},  // R5 fractional entry
        '{1'b1, 32'd24000000, 9'd162, 30'd50, 30'd100, 3'd0, 8'd7,  64'd557142857,  1'b0, 1'b0, 8'd67}, // R2 near miss
        '{1'b1, 32'd50000000, 9'd100, 30'd0,  30'd1,   3'd2, 8'd10, 64'd250000000,  1'b0, 1'b0, 8'd67}, // R6 lower edge
        '{1'b0, 32'd24000000, 9'd255, 30'd0,  30'd0,   3'd1, 8'd16, 64'd382500000,  1'b1, 1'b0, 8'd67}, // R6 high VCO
        '{1'b1, 32'd24000000, 9'd100, 30'd3,  30'd0,   3'd0, 8'd4,  64'd0,          1'b0, 1'b1, 8'd2},  // R7
        '{1'b0, 32'd24000000, 9'd200, 30'd3,  30'd0,   3'd0, 8'd12, 64'd400000000,  1'b0, 1'b0, 8'd67}, // R3 mfd 0 ignored
        '{1'b1, 32'd10000000, 9'd162, 30'd50, 30'd100, 3'd0, 8'd6,  64'd650000000,  1'b1, 1'b0, 8'd2},  // R5 R6 together
        '{1'b0, 32'd25000000, 9'd200, 30'd0,  30'd0,   3'd1, 8'd10, 64'd500000000,  1'b0, 1'b0, 8'd67}  // R6 upper edge
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        frac = 1'b0;
    logic [31:0] fref = '0;
    logic [8:0]  mfi = '0;
    logic [29:0] mfn = '0;
    logic [29:0] mfd = '0;
    logic [2:0]  rdiv = '0;
    logic [7:0]  odiv = '0;
    logic [63:0] rate;
    logic        done, rng, zro;

    int checks = 0;
    int fails = 0;

    always #5 clk = ~clk;

    pll_rate_calc u_pll_rate_calc (
        .clk(clk), .rst_n(rst_n), .start_i(start), .frac_mode_i(frac),
        .ref_freq_i(fref), .mfi_i(mfi), .mfn_i(mfn), .mfd_i(mfd),
        .rdiv_i(rdiv), .odiv_i(odiv), .rate_o(rate), .done_o(done),
        .range_err_o(rng), .div_zero_o(zro)
    );

    task automatic check(string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", what, act, exp);
        end
    endtask

    task automatic drive(vec_t v);
        frac = v.frac; fref = v.fref; mfi = v.mfi; mfn = v.mfn;
        mfd = v.mfd; rdiv = v.rdiv; odiv = v.odiv;
    endtask

    // Launch at a falling edge; count rising edges until done is seen.
    task automatic run(vec_t v, output int lat);
        @(negedge clk);
        drive(v);
        start = 1'b1;
        lat = 0;
        do begin
            @(posedge clk);
            lat++;
            @(negedge clk);
            start = 1'b0;
        end while (!done && lat < 300);
    endtask

    task automatic finish_report();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_report();
    end

    initial begin
        int lat;
        vec_t other;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: quiet during and after reset
        check("R1 rate in reset", rate, 0);
        check("R1 flags in reset", {done, rng, zro}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R1 outputs after reset", {rate, done, rng, zro}, 0);

        for (int i = 0; i < NV; i++) begin
            run(VECS[i], lat);
            check($sformatf("vec %0d rate (R2 R3 R4 R5)", i), rate, VECS[i].rate);
            check($sformatf("vec %0d flags (R6 R7)", i), {rng, zro}, {VECS[i].rng, VECS[i].zro});
            check($sformatf("vec %0d latency (R8)", i), 64'(lat), 64'(VECS[i].lat));
            @(negedge clk);
            check($sformatf("vec %0d done width (R9)", i), done, 0);
        end

        // R9: result held for several idle cycles
        repeat (5) @(negedge clk);
        check("R9 rate held", rate, VECS[NV-1].rate);

        // R3: integer mode with different mfn/mfd gives identical output
        other = VECS[2];
        other.mfn = 30'd123456;
        other.mfd = 30'd999;
        run(other, lat);
        check("R3 mfn/mfd ignored rate", rate, 64'd1200000000);
        check("R3 mfn/mfd ignored flags", {rng, zro}, 0);

        // R10: second start during division is ignored
        @(negedge clk);
        drive(VECS[1]);
        start = 1'b1;
        lat = 0;
        @(posedge clk); lat++;
        @(negedge clk); start = 1'b0;
        repeat (10) begin @(posedge clk); lat++; @(negedge clk); end
        drive(VECS[0]);
        start = 1'b1;
        @(posedge clk); lat++;
        @(negedge clk); start = 1'b0;
        while (!done && lat < 300) begin @(posedge clk); lat++; @(negedge clk); end
        check("R10 busy start rate", rate, VECS[1].rate);
        check("R10 busy start latency", 64'(lat), 64'd67);
        check("R10 busy start flags", {rng, zro}, 0);

        // R4: rdiv code 7 and odiv code 200
        other = '{1'b0, 32'd28000000, 9'd250, 30'd0, 30'd0, 3'd7, 8'd200, 64'd5000000, 1'b1, 1'b0, 8'd67};
        run(other, lat);
        check("R4 large codes rate", rate, other.rate);
        check("R6 large codes flags", {rng, zro}, {other.rng, other.zro});

        finish_report();
    end

endmodule